// File: doc/BRIEF.md
# Sparse Block Section Loader

This unit fills one vector register with a section of a sparse matrix stored in a column-blocked compressed layout. The matrix arrives as a stream of entries. Each entry holds a nonzero value, the column of that value inside its vertical block, and three flags: last entry of a segment, last entry of a vertical block, and last entry of the matrix. An n-by-n matrix is cut into ceil(n/S) vertical blocks of at most S columns, where S is the section length. Each block is cut again into S-by-S segments, so every block holds as many segments as there are blocks.

A load starts when a command is accepted. The unit then takes entries one per accepted beat and writes each one into the next element of the vector register. It stops when the section is full, or earlier on a condition that depends on the mode. Plain mode stops at a block or matrix end. Segmented mode also stops at each segment end. Grouped mode stops once K segment ends have been consumed in the current visit to a block. In grouped mode the stream visits K segments of every block in turn. It then signals that the K·S result buffer must be written back, and goes on with the next K segments. Each finished load reports its length and the block and segment of its first entry. From these, the caller knows which contiguous slice of the result vector the load affects.

Top module: `sparse_section_loader`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `ent_ready`, `done`, `done_flush` and `finished` are 0.
- R2: In plain mode (`cmd_mode` = 0, also for code 3), a load ends after S entries, or earlier on an entry with `ent_eob` or `ent_eom` set. `ent_eos` does not end a plain load.
- R3: Every accepted beat writes the entry into element `vr_idx`. Elements are written in order 0, 1, ..., len-1, and the entry that ends the load is included. Over a whole matrix, the load lengths add up to the number of entries in the stream.
- R4: In segmented mode (`cmd_mode` = 1), a load also ends on the first entry with `ent_eos` set.
- R5: In grouped mode (`cmd_mode` = 2), a load ends on a full section, on `ent_eob`, or on the entry that carries the K-th `ent_eos` of the current block visit. The count of `ent_eos` flags carries over between loads within one visit.
- R6: `done` is a one-cycle pulse in the cycle after the last beat. `done_len` is then between 1 and S.
- R7: `done_blk` and `done_seg` give the block and the segment of the load's first entry. In plain and segmented mode, the segment number advances by one on each `ent_eos` and returns to 0, with the block number advancing, on `ent_eob`. In grouped mode, blocks are visited 0..B-1 for segments g..g+K-1, and then again from block 0 with g increased by K.
- R8: `done_flush` is 1 with `done` exactly when a grouped-mode load closes the visit to the last block (number `cmd_blocks`-1).
- R9: An entry that both fills the section and carries `ent_eos` ends the load once, and advances the segment number only once.
- R10: After the entry with `ent_eom` set, `finished` goes to 1. From then until reset, `cmd_ready` and `ent_ready` stay 0 and no load starts.
- R11: `cmd_mode`, `cmd_k` and `cmd_blocks` are sampled only when a command is accepted. A `cmd_k` of 0 is taken as 1, and a value above KMAX is taken as KMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Load command request |
| cmd_ready | output | 1 | Unit idle and not finished; command accepted when both are high |
| cmd_mode | input | 2 | 0 plain, 1 segmented, 2 grouped, 3 plain |
| cmd_k | input | $clog2(KMAX+1) | Segments per block visit in grouped mode |
| cmd_blocks | input | BLK_W | Number of vertical blocks |
| ent_valid | input | 1 | Stream entry present |
| ent_ready | output | 1 | Unit is taking entries |
| ent_value | input | VAL_W | Nonzero value |
| ent_col | input | $clog2(SECT) | Column inside the vertical block |
| ent_eos | input | 1 | Last entry of a segment |
| ent_eob | input | 1 | Last entry of a vertical block |
| ent_eom | input | 1 | Last entry of the matrix |
| vr_we | output | 1 | Vector register element write |
| vr_idx | output | $clog2(SECT) | Element index being written |
| vr_value | output | VAL_W | Value written |
| vr_col | output | $clog2(SECT) | Column written alongside the value |
| done | output | 1 | Load complete pulse |
| done_len | output | $clog2(SECT+1) | Number of elements loaded |
| done_blk | output | BLK_W | Block of the first loaded entry |
| done_seg | output | BLK_W | Segment of the first loaded entry |
| done_flush | output | 1 | Result buffer must be written back |
| finished | output | 1 | Matrix end consumed |

## Verification
Some properties are checked on every cycle. `done` is a single-cycle pulse with a length in range. A beat at the last element, or a segment-end beat in segmented mode, is followed by `done`. A matrix-end beat is followed by `finished`, and after that the unit accepts neither commands nor entries. The grouped visit counter never reaches K. Other behaviour only the bench scenarios can show: the length of every load under random segment sizes, the block and segment numbering across passes, when `done_flush` fires, sampling of the command fields, and the case where a full section and a segment end fall on the same entry. The bench compares these against a model that labels each generated entry with its true block, segment and visit end.

// File: rtl/sec_pkg.sv
package sec_pkg;
   typedef enum logic [1:0] {
      MODE_PLAIN = 2'd0,
      MODE_SEG   = 2'd1,
      MODE_GRP   = 2'd2,
      MODE_ALT   = 2'd3
   } ld_mode_e;

   typedef struct packed {
      logic eos;
      logic eob;
      logic eom;
   } ent_flags_t;
endpackage

// File: rtl/sec_pos.sv
// Tracks block / segment position of the next stream entry and the
// grouped-mode visit bookkeeping.
module sec_pos
   import sec_pkg::*;
#(
   parameter int BLK_W = 8,
   parameter int K_W   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  ent_flags_t       flg,
   input  logic             grp_on,
   input  logic [K_W-1:0]   k,
   input  logic [BLK_W-1:0] nblk,
   output logic [BLK_W-1:0] blk,
   output logic [BLK_W-1:0] seg,
   output logic             visit_end,
   output logic             pass_end
);
   logic [BLK_W-1:0] blk_q, seg_q, grp_q;
   logic [K_W-1:0]   visit_q;

   assign visit_end = grp_on && beat &&
                      (flg.eob || (flg.eos && ((visit_q + K_W'(1)) == k)));
   assign pass_end  = visit_end && (blk_q == (nblk - BLK_W'(1)));
   assign blk = blk_q;
   assign seg = seg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q   <= '0;
         seg_q   <= '0;
         grp_q   <= '0;
         visit_q <= '0;
      end else if (beat) begin
         if (grp_on) begin
            if (visit_end) begin
               visit_q <= '0;
               if (pass_end) begin
                  blk_q <= '0;
                  grp_q <= grp_q + BLK_W'(k);
                  seg_q <= grp_q + BLK_W'(k);
               end else begin
                  blk_q <= blk_q + BLK_W'(1);
                  seg_q <= grp_q;
               end
            end else if (flg.eos) begin
               seg_q   <= seg_q + BLK_W'(1);
               visit_q <= visit_q + K_W'(1);
            end
         end else begin
            if (flg.eob) begin
               blk_q <= blk_q + BLK_W'(1);
               seg_q <= '0;
            end else if (flg.eos) begin
               seg_q <= seg_q + BLK_W'(1);
            end
         end
      end
   end

   assert_visit_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      grp_on |-> (visit_q < k));
endmodule

// File: rtl/sec_fill.sv
// Element index within the section and the load termination decision.
module sec_fill
   import sec_pkg::*;
#(
   parameter int SECT = 8,
   localparam int IDX_W = $clog2(SECT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             beat,
   input  ent_flags_t       flg,
   input  logic             seg_on,
   input  logic             visit_end,
   output logic [IDX_W-1:0] idx,
   output logic             last
);
   logic [IDX_W-1:0] idx_q;
   logic             full;

   assign full = (idx_q == IDX_W'(SECT - 1));
   assign last = beat && (full || flg.eob || flg.eom ||
                          (seg_on && flg.eos) || visit_end);
   assign idx  = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       idx_q <= '0;
      else if (last)    idx_q <= '0;
      else if (beat)    idx_q <= idx_q + IDX_W'(1);
   end
endmodule

// File: rtl/sparse_section_loader.sv
module sparse_section_loader
   import sec_pkg::*;
#(
   parameter int SECT   = 8,
   parameter int KMAX   = 8,
   parameter int BLK_W  = 8,
   parameter int VAL_W  = 16,
   parameter bit GRP_EN = 1'b1,
   localparam int IDX_W = $clog2(SECT),
   localparam int LEN_W = $clog2(SECT + 1),
   localparam int K_W   = $clog2(KMAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic [1:0]       cmd_mode,
   input  logic [K_W-1:0]   cmd_k,
   input  logic [BLK_W-1:0] cmd_blocks,
   input  logic             ent_valid,
   output logic             ent_ready,
   input  logic [VAL_W-1:0] ent_value,
   input  logic [IDX_W-1:0] ent_col,
   input  logic             ent_eos,
   input  logic             ent_eob,
   input  logic             ent_eom,
   output logic             vr_we,
   output logic [IDX_W-1:0] vr_idx,
   output logic [VAL_W-1:0] vr_value,
   output logic [IDX_W-1:0] vr_col,
   output logic             done,
   output logic [LEN_W-1:0] done_len,
   output logic [BLK_W-1:0] done_blk,
   output logic [BLK_W-1:0] done_seg,
   output logic             done_flush,
   output logic             finished
);
   if (SECT < 2 || SECT > 64) begin : g_bad_sect
      $error("SECT must lie in 2..64");
   end
   if (KMAX < 1 || KMAX > 8) begin : g_bad_kmax
      $error("KMAX must lie in 1..8");
   end
   if (K_W > BLK_W) begin : g_bad_blkw
      $error("BLK_W too narrow for KMAX");
   end

   ld_mode_e         mode_q;
   logic [K_W-1:0]   k_q, k_eff;
   logic [BLK_W-1:0] nblk_q;
   logic             busy_q, fin_q, done_q, flush_q;
   logic [LEN_W-1:0] len_q;
   logic [BLK_W-1:0] st_blk_q, st_seg_q;
   logic             accept, beat, last, grp_on, seg_on, visit_end, pass_end;
   logic [IDX_W-1:0] idx;
   logic [BLK_W-1:0] pos_blk, pos_seg;
   ent_flags_t       flg;

   assign flg       = '{eos: ent_eos, eob: ent_eob, eom: ent_eom};
   assign cmd_ready = !busy_q && !fin_q;
   assign ent_ready = busy_q;
   assign accept    = cmd_valid && cmd_ready;
   assign beat      = ent_valid && busy_q;
   assign seg_on    = (mode_q == MODE_SEG);

   if (GRP_EN) begin : g_grp
      assign grp_on = (mode_q == MODE_GRP);
   end else begin : g_nogrp
      assign grp_on = 1'b0;
   end

   always_comb begin
      if (cmd_k == '0)               k_eff = K_W'(1);
      else if (cmd_k > K_W'(KMAX))   k_eff = K_W'(KMAX);
      else                           k_eff = cmd_k;
   end

   sec_pos #(.BLK_W(BLK_W), .K_W(K_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .beat(beat), .flg(flg), .grp_on(grp_on),
      .k(k_q), .nblk(nblk_q), .blk(pos_blk), .seg(pos_seg),
      .visit_end(visit_end), .pass_end(pass_end)
   );

   sec_fill #(.SECT(SECT)) u_fill (
      .clk(clk), .rst_n(rst_n), .beat(beat), .flg(flg), .seg_on(seg_on),
      .visit_end(visit_end), .idx(idx), .last(last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_PLAIN;
         k_q      <= K_W'(1);
         nblk_q   <= '0;
         busy_q   <= 1'b0;
         fin_q    <= 1'b0;
         done_q   <= 1'b0;
         flush_q  <= 1'b0;
         len_q    <= '0;
         st_blk_q <= '0;
         st_seg_q <= '0;
      end else begin
         done_q  <= 1'b0;
         flush_q <= 1'b0;
         if (accept) begin
            busy_q   <= 1'b1;
            mode_q   <= ld_mode_e'(cmd_mode);
            k_q      <= k_eff;
            nblk_q   <= cmd_blocks;
            st_blk_q <= pos_blk;
            st_seg_q <= pos_seg;
         end
         if (last) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            flush_q <= pass_end;
            len_q   <= LEN_W'(idx) + LEN_W'(1);
            if (ent_eom) fin_q <= 1'b1;
         end
      end
   end

   assign vr_we      = beat;
   assign vr_idx     = idx;
   assign vr_value   = ent_value;
   assign vr_col     = ent_col;
   assign done       = done_q;
   assign done_len   = len_q;
   assign done_blk   = st_blk_q;
   assign done_seg   = st_seg_q;
   assign done_flush = flush_q;
   assign finished   = fin_q;

   assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (done_len != '0 && done_len <= LEN_W'(SECT)));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_full_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (vr_we && vr_idx == IDX_W'(SECT - 1)) |=> (done && done_len == LEN_W'(SECT)));
   assert_seg_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vr_we && mode_q == MODE_SEG && ent_eos) |=> done);
   assert_eom_fin_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (vr_we && ent_eom) |=> finished);
   assert_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      finished |-> (!cmd_ready && !ent_ready));
   assert_flush_grp_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_flush |-> (done && mode_q == MODE_GRP));
endmodule

// File: tb/sparse_section_loader_tb.sv
module sparse_section_loader_tb;
   localparam int SECT  = 8;
   localparam int KMAX  = 8;
   localparam int BLK_W = 8;
   localparam int VAL_W = 16;
   localparam int IDX_W = $clog2(SECT);
   localparam int LEN_W = $clog2(SECT + 1);
   localparam int K_W   = $clog2(KMAX + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_ready;
   logic [1:0] cmd_mode = '0;
   logic [K_W-1:0] cmd_k = '0;
   logic [BLK_W-1:0] cmd_blocks = '0;
   logic ent_valid = 1'b0, ent_ready;
   logic [VAL_W-1:0] ent_value = '0;
   logic [IDX_W-1:0] ent_col = '0;
   logic ent_eos = 1'b0, ent_eob = 1'b0, ent_eom = 1'b0;
   logic vr_we;
   logic [IDX_W-1:0] vr_idx, vr_col;
   logic [VAL_W-1:0] vr_value;
   logic done, done_flush, finished;
   logic [LEN_W-1:0] done_len;
   logic [BLK_W-1:0] done_blk, done_seg;

   always #5 clk = ~clk;

   sparse_section_loader #(.SECT(SECT), .KMAX(KMAX), .BLK_W(BLK_W), .VAL_W(VAL_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_mode(cmd_mode), .cmd_k(cmd_k), .cmd_blocks(cmd_blocks),
      .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_value(ent_value),
      .ent_col(ent_col), .ent_eos(ent_eos), .ent_eob(ent_eob), .ent_eom(ent_eom),
      .vr_we(vr_we), .vr_idx(vr_idx), .vr_value(vr_value), .vr_col(vr_col),
      .done(done), .done_len(done_len), .done_blk(done_blk), .done_seg(done_seg),
      .done_flush(done_flush), .finished(finished)
   );

   typedef struct {
      int val; int col; bit eos; bit eob; bit eom; int blk; int seg; bit vlast;
   } ent_t;
   typedef struct { int len; int blk; int seg; bit flush; } load_t;

   ent_t  q[$];
   load_t xq[$];
   int n_run = 0, n_fail = 0;

   function automatic void chk(bit ok, string tag, string what, longint act, longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog R6 actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   task automatic add_seg(int b, int s, bit lastseg, bit vend, bit fixed);
      int n;
      n = fixed ? SECT : 1 + int'($urandom % 5);
      for (int i = 0; i < n; i++) begin
         ent_t e;
         e.val = int'($urandom % 65536);
         e.col = int'($urandom % SECT);
         e.eos = (i == n - 1);
         e.eob = e.eos && lastseg;
         e.eom = 1'b0;
         e.blk = b; e.seg = s;
         e.vlast = e.eos && vend;
         q.push_back(e);
      end
   endtask

   task automatic build(int mode, int k, int nblk, bit fixed);
      q.delete();
      if (mode == 2) begin
         for (int g = 0; g < nblk; g += k) begin
            int top;
            top = (g + k < nblk) ? g + k : nblk;
            for (int b = 0; b < nblk; b++)
               for (int s = g; s < top; s++)
                  add_seg(b, s, s == nblk - 1, s == top - 1, fixed);
         end
      end else begin
         for (int b = 0; b < nblk; b++)
            for (int s = 0; s < nblk; s++)
               add_seg(b, s, s == nblk - 1, 1'b0, fixed);
      end
      q[q.size() - 1].eom = 1'b1;
   endtask

   task automatic predict(int mode, int nblk);
      load_t cur;
      int len;
      bit term;
      xq.delete();
      len = 0;
      cur = '{0, 0, 0, 1'b0};
      for (int i = 0; i < q.size(); i++) begin
         if (len == 0) begin cur.blk = q[i].blk; cur.seg = q[i].seg; end
         len++;
         term = (len == SECT) || q[i].eob || q[i].eom ||
                (mode == 1 && q[i].eos) || (mode == 2 && q[i].vlast);
         if (term) begin
            cur.len = len;
            cur.flush = (mode == 2) && q[i].vlast && (q[i].blk == nblk - 1);
            xq.push_back(cur);
            len = 0;
         end
      end
   endtask

   task automatic do_reset();
      cmd_valid = 1'b0; ent_valid = 1'b0; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", "cmd_ready", cmd_ready, 1);
      chk(ent_ready == 1'b0, "R1", "ent_ready", ent_ready, 0);
      chk(done == 1'b0 && done_flush == 1'b0, "R1", "done", done, 0);
      chk(finished == 1'b0, "R1", "finished", finished, 0);
   endtask

   // mode: 0 plain, 1 segmented, 2 grouped; k as driven on cmd_k
   task automatic run(int mode, int k, int nblk, bit fixed, string tag);
      int keff, ptr, nd, elem, guard, total;
      bit busy;
      keff = (k == 0) ? 1 : k;
      build(mode, keff, nblk, fixed);
      predict(mode, nblk);
      ptr = 0; nd = 0; elem = 0; guard = 0; total = 0; busy = 1'b0;
      while (nd < xq.size() && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (done) begin
            chk(int'(done_len) == xq[nd].len, tag, "length", done_len, xq[nd].len);
            chk(int'(done_blk) == xq[nd].blk, "R7", "block", done_blk, xq[nd].blk);
            chk(int'(done_seg) == xq[nd].seg, "R7", "segment", done_seg, xq[nd].seg);
            chk(done_flush == xq[nd].flush, "R8", "flush", done_flush, xq[nd].flush);
            total += int'(done_len);
            nd++; elem = 0; busy = 1'b0;
         end
         cmd_valid = !busy && ptr < q.size();
         // R11: garbage on command fields whenever no command is offered
         cmd_mode   = cmd_valid ? 2'(mode) : 2'(mode ^ 1);
         cmd_k      = cmd_valid ? K_W'(k) : K_W'(7);
         cmd_blocks = cmd_valid ? BLK_W'(nblk) : BLK_W'(nblk + 1);
         ent_valid = (ptr < q.size()) && ($urandom % 4 != 0);
         if (ptr < q.size()) begin
            ent_value = VAL_W'(q[ptr].val);
            ent_col   = IDX_W'(q[ptr].col);
            ent_eos   = q[ptr].eos;
            ent_eob   = q[ptr].eob;
            ent_eom   = q[ptr].eom;
         end
         #1;
         if (cmd_valid && cmd_ready) busy = 1'b1;
         if (ent_valid && ent_ready) begin
            chk(vr_we == 1'b1 && int'(vr_idx) == elem, "R3", "element index", vr_idx, elem);
            chk(int'(vr_value) == q[ptr].val && int'(vr_col) == q[ptr].col,
                "R3", "element value", vr_value, q[ptr].val);
            elem++; ptr++;
         end
      end
      chk(nd == xq.size(), tag, "loads completed", nd, xq.size());
      chk(total == q.size(), "R3", "entries loaded", total, q.size());
      @(negedge clk);
      cmd_valid = 1'b0; ent_valid = 1'b0;
      chk(finished == 1'b1, "R10", "finished", finished, 1);
      cmd_valid = 1'b1; ent_valid = 1'b1;
      for (int i = 0; i < 4; i++) begin
         #1;
         chk(cmd_ready == 1'b0 && ent_ready == 1'b0, "R10", "locked ready",
             {cmd_ready, ent_ready}, 0);
         @(negedge clk);
         chk(done == 1'b0, "R10", "no load after end", done, 0);
      end
      cmd_valid = 1'b0; ent_valid = 1'b0;
   endtask

   initial begin
      do_reset(); run(0, 2, 3, 1'b0, "R2");
      do_reset(); run(1, 2, 3, 1'b0, "R4");
      do_reset(); run(1, 2, 3, 1'b1, "R9");
      do_reset(); run(2, 2, 3, 1'b0, "R5");
      do_reset(); run(2, 0, 3, 1'b0, "R11");
      do_reset(); run(2, 3, 3, 1'b0, "R5");
      do_reset(); run(2, 2, 5, 1'b0, "R8");
      do_reset(); run(0, 2, 2, 1'b1, "R2");
      do_reset(); run(2, 2, 3, 1'b1, "R9");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule